// File: doc/BRIEF.md
# Serial Register-Access Slave Port

This block sits between an external host's four-wire serial link and a bank of 128 byte-wide control registers. The host pulls the active-low select down, clocks in a command byte holding a 7-bit register address and a direction flag, and then moves one or more data bytes. Each byte after the first in the same frame goes to the next address, and the address wraps from 127 back to 0. The frame ends when select returns high.

All serial inputs are brought into the system clock through two-flop synchronizers. Serial clock edges are found by comparing successive synchronized samples, so the system clock must run at least four times faster than the serial clock. The link uses clock polarity 0 and phase 1. The serial clock idles low. The host presents MOSI at the rising edge, and the slave samples it at the falling edge. The register bank itself is outside the block. The block reaches it through a registered write port and a combinational read port.

Top module: `spi_regport`

## Requirements
- R1: MOSI is sampled on each falling edge of the serial clock while select is low, most significant bit first.
- R2: After a falling edge of select, the first 8 sampled bits form the command. Bits 7 down to 1 carry the register address, and bit 0 carries the direction (0 = write, 1 = read).
- R3: For a write, each complete 8-bit data byte produces exactly one single-cycle `rf_we` pulse, with `rf_waddr` set to the target address and `rf_wdata` set to the byte. No other write occurs.
- R4: For a read, the addressed register is shifted out on MISO most significant bit first. The first bit is present before the first rising edge of the data byte. Each later bit appears after the falling edge that sampled the previous bit.
- R5: While select stays low, every further data byte uses the address one above the previous one, and the address wraps from 127 to 0. This holds for both reads and writes.
- R6: If select rises before a byte is complete, that byte is discarded and produces no write. After that, only a new falling edge of select starts a new command.
- R7: `miso_oe` is 1 during a frame and 0 once select is high. MISO is 0 whenever `miso_oe` is 0, during the command byte, and during write data bytes.
- R8: After reset, `miso_oe`, `rf_we` and `miso` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host, idles low |
| ss_n | input | 1 | Active-low frame select |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| miso_oe | output | 1 | Drive enable for MISO; the pad is tri-stated when this is 0 |
| rf_waddr | output | ADDR_W | Register write address |
| rf_wdata | output | DATA_W | Register write data |
| rf_we | output | 1 | Single-cycle register write strobe |
| rf_raddr | output | ADDR_W | Register read address |
| rf_rdata | input | DATA_W | Register read data, combinational from `rf_raddr` |

## Verification
The bench builds the block with its default 7-bit address and 8-bit data. It drives the serial clock at one eighth of the system clock rate, which leaves two spare system cycles after the synchronizer delay before the host's next edge. With these defaults, bursts that start at 126 cross the 127-to-0 wrap in only three bytes. Frames cut off after 3 command bits or 5 data bits test the discard path against a real register bank that the bench serves and checks on every clock.

// File: rtl/spi_regport.sv
`timescale 1ns/1ps
module spi_regport #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              ss_n,
  input  logic              mosi,
  output logic              miso,
  output logic              miso_oe,
  output logic [ADDR_W-1:0] rf_waddr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              rf_we,
  output logic [ADDR_W-1:0] rf_raddr,
  input  logic [DATA_W-1:0] rf_rdata
);
  localparam int CMD_W = ADDR_W + 1;
  localparam int MAXW  = (CMD_W > DATA_W) ? CMD_W : DATA_W;
  localparam int CNT_W = $clog2(MAXW);
  localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

  logic [2:0] sclk_p, ss_p;
  logic [1:0] mosi_p;
  logic active, in_cmd, is_read;
  logic [CNT_W-1:0]  cnt;
  logic [MAXW-1:0]   rx;
  logic [DATA_W-1:0] tx;
  logic [ADDR_W-1:0] addr;

  wire sclk_fall = sclk_p[2] & ~sclk_p[1];
  wire ss_fall   = ss_p[2] & ~ss_p[1];
  wire ss_rise   = ~ss_p[2] & ss_p[1];
  wire bit_fall  = active & sclk_fall;
  wire last      = in_cmd ? (cnt == CMD_LAST) : (cnt == DATA_LAST);
  wire byte_done = bit_fall & last;
  wire [ADDR_W-1:0] addr_nx = addr + 1'b1;

  assign rf_raddr = in_cmd ? rx[ADDR_W-1:0] : addr_nx;
  assign miso_oe  = active;
  assign miso     = active & tx[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p <= '0;
      ss_p   <= '1;
      mosi_p <= '0;
    end else begin
      sclk_p <= {sclk_p[1:0], sclk};
      ss_p   <= {ss_p[1:0], ss_n};
      mosi_p <= {mosi_p[0], mosi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      in_cmd   <= 1'b0;
      is_read  <= 1'b0;
      cnt      <= '0;
      rx       <= '0;
      tx       <= '0;
      addr     <= '0;
      rf_we    <= 1'b0;
      rf_waddr <= '0;
      rf_wdata <= '0;
    end else begin
      rf_we <= 1'b0;
      if (ss_fall) begin
        active  <= 1'b1;
        in_cmd  <= 1'b1;
        is_read <= 1'b0;
        cnt     <= '0;
        tx      <= '0;
      end else if (ss_rise) begin
        active <= 1'b0;
      end else if (bit_fall) begin
        rx  <= {rx[MAXW-2:0], mosi_p[1]};
        tx  <= {tx[DATA_W-2:0], 1'b0};
        cnt <= last ? '0 : cnt + 1'b1;
        if (last) begin
          if (in_cmd) begin
            in_cmd  <= 1'b0;
            addr    <= rx[ADDR_W-1:0];
            is_read <= mosi_p[1];
            if (mosi_p[1]) tx <= rf_rdata;
          end else begin
            addr <= addr_nx;
            if (is_read) begin
              tx <= rf_rdata;
            end else begin
              rf_we    <= 1'b1;
              rf_waddr <= addr;
              rf_wdata <= {rx[DATA_W-2:0], mosi_p[1]};
            end
          end
        end
      end
    end
  end

  a_r3_we_single: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> !rf_we);
  a_r6_we_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> $past(active));
  a_r7_oe_drops: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ss_p[1]) |=> !miso_oe);
  a_r7_quiet_write: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !is_read) |-> !miso);
  a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !in_cmd) |=> addr == ADDR_W'($past(addr) + 1'b1));
  a_r2_cmd_once: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && in_cmd) |=> !in_cmd);
endmodule

// File: tb/spi_regport_tb.sv
`timescale 1ns/1ps
module spi_regport_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;

  logic clk = 0, rst_n = 0, sclk = 0, ss_n = 1, mosi = 0;
  logic miso, miso_oe, rf_we;
  logic [6:0] rf_waddr, rf_raddr;
  logic [7:0] rf_wdata, rf_rdata;
  logic [7:0] mem [128];
  logic [7:0] shadow [128];
  int wq[$];
  int vectors = 0, miscompares = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_regport dut_i (.clk(clk), .rst_n(rst_n), .sclk(sclk), .ss_n(ss_n), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .rf_we(rf_we), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata));

  assign rf_rdata = mem[rf_raddr];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) mem[i] <= 8'(i * 7 + 3);
    end else if (rf_we) begin
      mem[rf_waddr] <= rf_wdata;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      vectors++;
      if (!miso_oe && miso) begin
        miscompares++;
        $display("FAIL R7 miso while disabled actual=1 expected=0");
      end
      if (rf_we) begin
        if (wq.size() == 0) begin
          miscompares++;
          $display("FAIL R3/R6 unexpected write actual=%0h:%0h expected=none", rf_waddr, rf_wdata);
        end else begin
          chk("R3 write addr/data", {rf_waddr, rf_wdata}, wq.pop_front());
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bit_xfer(input bit mo, output bit mi);
    sclk = 1; mosi = mo;
    tick(HALF);
    mi = miso;
    sclk = 0;
    tick(HALF);
  endtask

  task automatic byte_xfer(input logic [7:0] b, input int nbits, output logic [7:0] r);
    bit mi;
    r = '0;
    for (int k = 7; k >= 8 - nbits; k--) begin
      bit_xfer(b[k], mi);
      r[k] = mi;
    end
  endtask

  task automatic start_frame;
    ss_n = 0; tick(4);
  endtask

  task automatic end_frame;
    ss_n = 1; tick(6);
    chk("R7 oe low after select high", miso_oe, 0);
  endtask

  task automatic wr_burst(input int a, input int n, input int seed);
    logic [7:0] r, d;
    int ad;
    start_frame();
    byte_xfer({7'(a), 1'b0}, 8, r);
    chk("R7 miso quiet in command", r, 0);
    chk("R7 oe high in frame", miso_oe, 1);
    for (int k = 0; k < n; k++) begin
      ad = (a + k) % 128;
      d = 8'(seed + k * 37);
      wq.push_back({ad[6:0], d});
      shadow[ad] = d;
      byte_xfer(d, 8, r);
      chk("R7 miso quiet in write data", r, 0);
    end
    end_frame();
    chk("R3 all writes seen (R5 burst)", wq.size(), 0);
  endtask

  task automatic rd_burst(input int a, input int n);
    logic [7:0] r;
    int ad;
    start_frame();
    byte_xfer({7'(a), 1'b1}, 8, r);
    for (int k = 0; k < n; k++) begin
      ad = (a + k) % 128;
      byte_xfer(8'h00, 8, r);
      chk(k == 0 ? "R4 read data" : "R5 burst read next address", r, shadow[ad]);
    end
    end_frame();
  endtask

  initial begin
    logic [7:0] r;
    for (int i = 0; i < 128; i++) shadow[i] = 8'(i * 7 + 3);
    tick(3);
    chk("R8 reset oe", miso_oe, 0);
    chk("R8 reset we", rf_we, 0);
    chk("R8 reset miso", miso, 0);
    rst_n = 1;
    tick(4);
    wr_burst(5, 1, 8'hA5);               // R1 R2 R3 single write
    rd_burst(5, 1);                      // R4
    rd_burst(64, 1);                     // R4 untouched register
    wr_burst(126, 3, 8'h3C);             // R5 wrap on write
    rd_burst(125, 5);                    // R5 wrap on read
    wr_burst(40, 4, 8'hF0);
    rd_burst(40, 4);
    start_frame();                       // R6 partial data byte
    byte_xfer({7'd10, 1'b0}, 8, r);
    byte_xfer(8'hFF, 5, r);
    end_frame();
    rd_burst(10, 1);                     // R6 register unchanged
    start_frame();                       // R6 partial command
    byte_xfer(8'b1010_1010, 3, r);
    end_frame();
    wr_burst(20, 1, 8'h5A);              // R6 next frame is a command
    rd_burst(20, 2);
    wr_burst(127, 1, 8'h81);
    rd_burst(127, 2);
    chk("R3 no stray writes", wq.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule